// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Interrupt

This block supervises software by counting a slow clock up toward a programmable overflow point. If software fails to restart the count in time, the block issues a one-cycle reset request. Software restarts the count by writing a fixed key byte through a single-register write port. The restart is honoured only while a "window" is open. The window is the last part of each count period. A write with the wrong key, or a write made before the window opens, is treated as a fault and also raises a reset request.

All settings come from an 8-bit configuration byte. The byte is captured on the first clock edge after reset release and stays frozen until the next reset. It sets five things:
- whether the timer runs at all;
- which of eight overflow periods is used;
- how wide the window is;
- whether an early-warning interrupt pulse fires at three quarters of the period;
- whether counting continues while the system is in a low-power standby state.

The asynchronous reset input is released synchronously inside the block. The oscillator, the reset generator and the interrupt controller sit outside this block.

Top module: `wwdt_top`

## Requirements
- R1: The configuration byte is captured once, on the first clock edge after the internal reset releases. Any later change of `cfg_byte_i` has no effect until the next reset. The fields are:
  - bit 7: interrupt enable;
  - bits 6:5: window select;
  - bit 4: timer enable;
  - bits 3:1: overflow select;
  - bit 0: standby-run enable.
- R2: The overflow select codes 0 to 7 give periods of 2^10, 2^11, 2^12, 2^13, 2^15, 2^17, 2^18 and 2^20 clocks. When nothing intervenes, `rst_req_o` rises exactly one period after the count was last cleared.
- R3: `rst_req_o` is a one-cycle pulse. Every reset request clears the count, so the next overflow comes one full period after the request.
- R4: While the timer is running, a write whose data differs from 0xAC raises `rst_req_o` on the next cycle.
- R5: The window opens at a count equal to the period minus a share of the period. The share depends on the window select:
  - code 0: 1/4 of the period;
  - code 1: 1/2;
  - code 2: 3/4;
  - code 3: all of it.
  
  A key write made while the count is below that opening point raises `rst_req_o` on the next cycle.
- R6: A key write (0xAC) made inside the window clears the count without a reset request. This holds even when the write lands on the last count of the period, where it suppresses that overflow.
- R7: With bit 7 set, `irq_o` pulses for one cycle when the count reaches three quarters of the period, once per period. With bit 7 clear, `irq_o` stays low.
- R8: With bit 4 clear, the count is held at zero and both outputs stay low, whatever is written.
- R9: With bit 0 clear, counting pauses while `standby_i` is high. With bit 0 set, `standby_i` has no effect.
- R10: While `arst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed counting clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_i | input | 8 | Configuration byte, captured after reset |
| standby_i | input | 1 | System is in a low-power standby state |
| wr_en_i | input | 1 | Write strobe for the restart register |
| wr_data_i | input | 8 | Data written to the restart register |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | One-cycle early-warning interrupt |

## Verification
A restart write and the counter's overflow can both fall on the same cycle: the last count of the period.

The bench provokes this by anchoring on an overflow pulse and then counting clock edges so that the write lands exactly on that count. It does this once with the correct key and once with a wrong one.

With the correct key, no pulse may appear and the next overflow must come a full period after the write. With a wrong key, exactly one single-cycle pulse must appear, and the following overflow must again come a full period later.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  // Field order follows the bit positions of the configuration byte (MSB first).
  typedef struct packed {
    logic       irq_en;    // bit 7
    logic [1:0] win_sel;   // bits 6:5
    logic       wdt_en;    // bit 4
    logic [2:0] ovf_sel;   // bits 3:1
    logic       stby_run;  // bit 0
  } wwdt_cfg_t;

  // Exponent of two for each overflow select code.
  function automatic int ovf_exp(input logic [2:0] sel);
    case (sel)
      3'd0:    return 10;
      3'd1:    return 11;
      3'd2:    return 12;
      3'd3:    return 13;
      3'd4:    return 15;
      3'd5:    return 17;
      3'd6:    return 18;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/wwdt_rst_sync.sv
module wwdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wwdt_cfg_latch.sv
module wwdt_cfg_latch
  import wwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_byte_i,
  output wwdt_cfg_t  cfg_o,
  output logic       vld_o
);
  wwdt_cfg_t cfg_q, cfg_d;
  logic      vld_q, vld_d;

  // Capture once after reset release, then hold.
  always_comb begin
    cfg_d = cfg_q;
    vld_d = 1'b1;
    if (!vld_q) cfg_d = wwdt_cfg_t'(cfg_byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      vld_q <= vld_d;
    end
  end

  assign cfg_o = cfg_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/wwdt_restart_chk.sv
module wwdt_restart_chk #(
  parameter int         CNT_W = 20,
  parameter logic [7:0] KEY   = 8'hAC
) (
  input  logic             armed_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] win_start_i,
  output logic             good_o,
  output logic             bad_o
);
  logic hit, key_ok, win_ok;

  always_comb begin
    hit    = wr_en_i & armed_i;
    key_ok = (wr_data_i == KEY);
    win_ok = (cnt_i >= win_start_i);
    good_o = hit & key_ok & win_ok;
    bad_o  = hit & ~(key_ok & win_ok);
  end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
  import wwdt_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_i,
  input  logic             stall_i,
  input  logic             clear_i,
  input  logic             irq_en_i,
  input  logic [2:0]       ovf_sel_i,
  input  logic [1:0]       win_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] last_o,
  output logic [CNT_W-1:0] irq_pt_o,
  output logic [CNT_W-1:0] win_start_o,
  output logic             ovf_hit_o,
  output logic             irq_hit_o
);
  localparam int SPAN_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SPAN_W-1:0] span, quarter;
  int                shamt;
  logic              step;

  // Period-derived compare points.
  always_comb begin
    shamt = ovf_exp(ovf_sel_i);
    if (shamt > CNT_W) shamt = CNT_W;
    span     = SPAN_W'(1) << shamt;
    quarter  = span >> 2;
    last_o   = CNT_W'(span - SPAN_W'(1));
    irq_pt_o = CNT_W'(span - quarter);
    case (win_sel_i)
      2'd0:    win_start_o = CNT_W'(span - quarter);
      2'd1:    win_start_o = CNT_W'(span >> 1);
      2'd2:    win_start_o = CNT_W'(quarter);
      default: win_start_o = '0;
    endcase
  end

  // Next-state: a clear (good or bad write) wins over overflow and interrupt.
  always_comb begin
    step      = armed_i & ~stall_i & ~clear_i;
    ovf_hit_o = step & (cnt_q == last_o);
    irq_hit_o = step & irq_en_i & (cnt_q == irq_pt_o - CNT_W'(1));
    if (!armed_i || clear_i || ovf_hit_o) cnt_d = '0;
    else if (step)                        cnt_d = cnt_q + CNT_W'(1);
    else                                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int         CNT_W       = 20,
  parameter logic [7:0] KEY         = 8'hAC,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic [7:0] cfg_byte_i,
  input  logic       standby_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic       rst_req_o,
  output logic       irq_o
);
  logic             rst_n_s;
  wwdt_cfg_t        cfg_q;
  logic             cfg_vld;
  logic             armed, stall, wr_good, wr_bad, ovf_hit, irq_hit;
  logic [CNT_W-1:0] cnt_q, last_cnt, irq_pt, win_start;
  logic             rst_req_d, rst_req_q, irq_d, irq_q;

  wwdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .srst_n_o(rst_n_s)
  );

  wwdt_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n_s), .cfg_byte_i(cfg_byte_i),
    .cfg_o(cfg_q), .vld_o(cfg_vld)
  );

  assign armed = cfg_vld & cfg_q.wdt_en;
  assign stall = standby_i & ~cfg_q.stby_run;

  wwdt_restart_chk #(.CNT_W(CNT_W), .KEY(KEY)) u_chk (
    .armed_i(armed), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cnt_i(cnt_q), .win_start_i(win_start),
    .good_o(wr_good), .bad_o(wr_bad)
  );

  wwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .armed_i(armed), .stall_i(stall),
    .clear_i(wr_good | wr_bad), .irq_en_i(cfg_q.irq_en),
    .ovf_sel_i(cfg_q.ovf_sel), .win_sel_i(cfg_q.win_sel),
    .cnt_o(cnt_q), .last_o(last_cnt), .irq_pt_o(irq_pt),
    .win_start_o(win_start), .ovf_hit_o(ovf_hit), .irq_hit_o(irq_hit)
  );

  always_comb begin
    rst_req_d = wr_bad | ovf_hit;
    irq_d     = irq_hit;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rst_req_q <= rst_req_d;
      irq_q     <= irq_d;
    end
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
#(
  parameter int         CNT_W = 20,
  parameter logic [7:0] KEY   = 8'hAC
) (
  input logic             clk,
  input logic             rst_n,
  input wwdt_cfg_t        cfg_q,
  input logic             cfg_vld,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] last_cnt,
  input logic [CNT_W-1:0] irq_pt,
  input logic [CNT_W-1:0] win_start,
  input logic             standby_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic             rst_req_o,
  input logic             irq_o
);
  logic armed;
  assign armed = cfg_vld & cfg_q.wdt_en;

  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_vld |=> (cfg_vld && $stable(cfg_q)));

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt);

  a_r3_cleared_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (cnt_q == '0));

  a_r4_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en_i && wr_data_i != KEY) |=> rst_req_o);

  a_r5_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en_i && cnt_q < win_start) |=> rst_req_o);

  a_r6_good_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_en_i && wr_data_i == KEY && cnt_q >= win_start)
      |=> (!rst_req_o && cnt_q == '0));

  a_r7_irq_point: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cnt_q == irq_pt));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.irq_en |-> !irq_o);

  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.wdt_en |-> (!rst_req_o && !irq_o && cnt_q == '0));

  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && standby_i && !cfg_q.stby_run && !wr_en_i) |=> $stable(cnt_q));
endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W), .KEY(KEY)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .cfg_q(cfg_q), .cfg_vld(cfg_vld),
  .cnt_q(cnt_q), .last_cnt(last_cnt), .irq_pt(irq_pt), .win_start(win_start),
  .standby_i(standby_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .rst_req_o(rst_req_o), .irq_o(irq_o)
);

// File: tb/wwdt_top_tb_top.sv
module wwdt_top_tb_top;
  localparam int         CNT_W = 20;
  localparam logic [7:0] KEY   = 8'hAC;
  localparam int         NV    = 13;

  // {cfg[7:0], data[7:0], offset[15:0], expect_reset}
  localparam logic [32:0] VEC [NV] = '{
    {8'h10, 8'hAC, 16'd800,  1'b0},  // R5/R6 inside 25% window
    {8'h10, 8'hAC, 16'd700,  1'b1},  // R5 before 25% window
    {8'h10, 8'hAB, 16'd800,  1'b1},  // R4 wrong key in window
    {8'h10, 8'hAC, 16'd1023, 1'b0},  // R6 restart on last count
    {8'h10, 8'h00, 16'd1023, 1'b1},  // R4 bad key on last count
    {8'h30, 8'hAC, 16'd600,  1'b0},  // R5 50% window open
    {8'h30, 8'hAC, 16'd511,  1'b1},  // R5 50% window closed
    {8'h50, 8'hAC, 16'd256,  1'b0},  // R5 75% window edge
    {8'h50, 8'hAC, 16'd255,  1'b1},  // R5 75% one early
    {8'h70, 8'hAC, 16'd3,    1'b0},  // R5 100% window
    {8'h12, 8'hAC, 16'd1536, 1'b0},  // R2 2^11 window edge
    {8'h12, 8'hAC, 16'd1535, 1'b1},  // R2 2^11 one early
    {8'h14, 8'h5A, 16'd100,  1'b1}   // R4 2^12 wrong key
  };

  logic       clk;
  logic       arst_n;
  logic [7:0] cfg_in;
  logic       standby, wr_en;
  logic [7:0] wr_data;
  logic       rst_req, irq;
  int         checks, errors;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  wwdt_top #(.CNT_W(CNT_W), .KEY(KEY)) dut_i (
    .clk(clk), .arst_n(arst_n), .cfg_byte_i(cfg_in), .standby_i(standby),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rst_req_o(rst_req), .irq_o(irq)
  );

  function automatic int span_of(input logic [7:0] c);
    case (c[3:1])
      3'd0: return 1024;     3'd1: return 2048;
      3'd2: return 4096;     3'd3: return 8192;
      3'd4: return 32768;    3'd5: return 131072;
      3'd6: return 262144;   default: return 1048576;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_n(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [7:0] c);
    arst_n = 1'b0; cfg_in = c; standby = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    step(3);
    arst_n = 1'b1;
  endtask

  // Wait for an overflow pulse: the sample where it is seen is count 0.
  task automatic anchor(input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      step(1);
      if (rst_req === 1'b1) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_count(input int n, output int rs, output int is);
    rs = 0; is = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (rst_req === 1'b1) rs++;
      if (irq === 1'b1) is++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] c, d;
    int off, sp, rs, is, rs2, is2;
    logic e;
    bit ok;
    checks = 0; errors = 0;

    // R10: outputs low during reset
    arst_n = 1'b0; cfg_in = 8'h90; standby = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    step(2);
    check("R10 rst_req in reset", rst_req, 1'b0);
    check("R10 irq in reset", irq, 1'b0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      c = VEC[v][32:25]; d = VEC[v][24:17]; off = int'(VEC[v][16:1]); e = VEC[v][0];
      sp = span_of(c);
      start(c);
      anchor(4 * sp + 16, ok);
      check("R2 first overflow seen", ok, 1'b1);
      step(off);
      wr_en = 1'b1; wr_data = d;
      step(1);
      wr_en = 1'b0;
      check($sformatf("R4/R5/R6 vec %0d response", v), rst_req, e);
      step(1);
      check($sformatf("R3 vec %0d single pulse", v), rst_req, 1'b0);
      step(sp - 2);
      check($sformatf("R2 vec %0d no early overflow", v), rst_req, 1'b0);
      step(1);
      check($sformatf("R3/R6 vec %0d overflow a period later", v), rst_req, 1'b1);
    end

    // R7: interrupt at three quarters, once per period
    start(8'h90);
    anchor(4200, ok);
    run_count(767, rs, is);
    check_n("R7 no irq before 3/4", is, 0);
    step(1);
    check("R7 irq at count 768", irq, 1'b1);
    run_count(255, rs, is);
    check_n("R7 irq only once", is, 0);
    check_n("R7 no reset before overflow", rs, 0);
    step(1);
    check("R2 overflow at 1024", rst_req, 1'b1);

    // R7: interrupt disabled
    start(8'h10);
    anchor(4200, ok);
    run_count(1024, rs, is);
    check_n("R7 irq off stays low", is, 0);
    check_n("R2 one overflow per period", rs, 1);

    // R8: timer disabled ignores writes and never fires
    start(8'h00);
    run_count(1500, rs, is);
    wr_en = 1'b1; wr_data = 8'h00; step(1);
    wr_data = 8'hAC; step(1);
    wr_en = 1'b0;
    run_count(2000, rs2, is2);
    check_n("R8 disabled no reset", rs + rs2, 0);
    check_n("R8 disabled no irq", is + is2, 0);

    // R9: standby stalls counting when bit 0 clear
    start(8'h10);
    anchor(4200, ok);
    run_count(100, rs, is);
    standby = 1'b1;
    run_count(500, rs2, is2);
    standby = 1'b0;
    check_n("R9 no reset during stall", rs2, 0);
    run_count(923, rs, is);
    check_n("R9 overflow delayed", rs, 0);
    step(1);
    check("R9 overflow after 1024 counted cycles", rst_req, 1'b1);

    // R9: standby ignored when bit 0 set
    start(8'h11);
    anchor(4200, ok);
    step(100);
    standby = 1'b1;
    run_count(500, rs, is);
    standby = 1'b0;
    run_count(423, rs2, is2);
    check_n("R9 no early reset with standby run", rs + rs2, 0);
    step(1);
    check("R9 standby run keeps period", rst_req, 1'b1);

    // R1: configuration change after capture has no effect
    start(8'h10);
    anchor(4200, ok);
    cfg_in = 8'h00;
    run_count(1023, rs, is);
    check_n("R1 no early reset after cfg change", rs, 0);
    step(1);
    check("R1 captured config still active", rst_req, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule